// File: doc/BRIEF.md
# Serial SAR Converter Sample Reader

This block is an SPI master that fetches one conversion result from an external successive-approximation converter. The supported parts differ in resolution (10, 12 or 13 bits) and input count (1, 2, 4 or 8). The host supplies a channel number, a differential flag and a device-type code, then pulses `start`. For parts with several inputs, the block shifts out an eight-bit command that selects the input and the input mode. It then clocks in two result bytes without releasing chip select. Parts with a single input have no data-in line, so only the two result bytes are clocked.

When the last bit is in, the block aligns the received bits to the right for that device type. It sign-extends the 13-bit result and zero-extends the others. It presents the 16-bit value together with a done pulse one clock long. The serial clock runs at the system clock divided by `2*CLK_DIV`, in SPI mode 0.

Top module: `sar_spi_reader`

## Requirements
- R1: After reset, cs_n is 1, and sclk, mosi, busy, done and result are all 0.
- R2: sclk idles low. Each sclk phase lasts CLK_DIV clocks. mosi changes only on falling sclk edges, and miso is sampled on rising edges.
- R3: For device codes 1 and 5 (two inputs), the command is 8'b0001_dc00, sent MSB first. Here d is the inverse of `diff` and c is chan[0].
- R4: For device codes 2 and 6 (four inputs), the command is 8'b01d0_cc00 with cc = chan[1:0]. For codes 3 and 7 (eight inputs), it is 8'b01dc_cc00 with ccc = chan[2:0].
- R5: For device codes 0, 4 and 8 (one input), no command is sent. mosi stays 0 and exactly 16 sclk cycles occur.
- R6: For multi-input codes, exactly 24 sclk cycles occur while cs_n stays low the whole time: 8 command bits, then 16 receive bits.
- R7: Let b0 and b1 be the first and second received bytes. For 10-bit parts, the result is the low 10 bits of (b0<<5 | b1>>3) for code 0, or of (b0<<2 | b1>>6) for codes 1 to 3.
- R8: For 12-bit parts, the result is the low 12 bits of (b0<<7 | b1>>1) for code 4, or of (b0<<4 | b1>>4) for codes 5 to 7.
- R9: For code 8 (codes 9 to 15 behave the same), the result is {b0[4:0], b1} sign-extended from bit 12 to 16 bits.
- R10: done is high for exactly one clock, in the cycle cs_n rises. result holds its value until the next done.
- R11: A start that arrives while busy is high launches no transfer and has no effect on the transfer in progress.
- R12: Between two transfers, cs_n stays high for at least 2*CLK_DIV clocks (one sclk period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one sample (taken only when idle) |
| dev | input | 4 | Device-type code (0-8) |
| chan | input | 3 | Input channel number |
| diff | input | 1 | 1 = differential pair, 0 = single-ended |
| busy | output | 1 | Transfer or inter-frame gap in progress |
| done | output | 1 | One-clock pulse when result is updated |
| result | output | 16 | Aligned sample, sign-extended for code 8 |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Sample data from the converter |

## Verification
The end of one frame and the request for the next can fall in the same cycle. done pulses and cs_n rises exactly when a host that chains requests raises `start` again. To provoke this, the bench raises `start` in the done cycle and holds it until chip select falls. It then judges that exactly one frame starts, only after the full gap, and that the earlier result is scored correctly. The bench also toggles `start` with a different device code in the middle of a frame. It confirms that the frame count, the command bits and the result still match that frame's original request.

// File: rtl/sar_spi_reader.sv
module sar_spi_reader #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  dev,
  input  logic [2:0]  chan,
  input  logic        diff,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int CW = $clog2(2 * CLK_DIV + 1);
  localparam logic [CW-1:0] HALF_END = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(2 * CLK_DIV - 1);

  typedef enum logic [1:0] {IDLE, XFER, GAP} state_t;
  state_t state;

  logic [CW-1:0] cnt;
  logic [4:0]    bitn;
  logic [3:0]    dv;
  logic [7:0]    tx;
  logic [15:0]   rx;
  logic [7:0]    cmd;
  logic [15:0]   ext;
  logic          multi_req, multi;

  assign multi_req = (dev[1:0] != 2'd0) && !dev[3];
  assign multi     = (dv[1:0] != 2'd0) && !dv[3];
  assign busy      = (state != IDLE);
  assign mosi      = !cs_n && tx[7];

  always_comb begin
    case (dev)
      4'd1, 4'd5: cmd = {3'b000, 1'b1, !diff, chan[0], 2'b00};
      4'd2, 4'd6: cmd = {2'b01, !diff, 1'b0, chan[1:0], 2'b00};
      4'd3, 4'd7: cmd = {2'b01, !diff, chan, 2'b00};
      default:    cmd = 8'h00;
    endcase
  end

  always_comb begin
    case (dv)
      4'd0:             ext = {6'd0, rx[12:8], rx[7:3]};
      4'd1, 4'd2, 4'd3: ext = {6'd0, rx[15:8], rx[7:6]};
      4'd4:             ext = {4'd0, rx[12:8], rx[7:1]};
      4'd5, 4'd6, 4'd7: ext = {4'd0, rx[15:8], rx[7:4]};
      default:          ext = {{3{rx[12]}}, rx[12:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      cnt    <= '0;
      bitn   <= '0;
      dv     <= '0;
      tx     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state <= XFER;
          dv    <= dev;
          tx    <= multi_req ? cmd : 8'h00;
          cnt   <= '0;
          bitn  <= '0;
          cs_n  <= 1'b0;
        end
        XFER: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              rx   <= {rx[14:0], miso};
            end else begin
              sclk <= 1'b0;
              tx   <= {tx[6:0], 1'b0};
              if (bitn == (multi ? 5'd23 : 5'd15)) begin
                state  <= GAP;
                cs_n   <= 1'b1;
                done   <= 1'b1;
                result <= ext;
              end else begin
                bitn <= bitn + 5'd1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == GAP_END) begin
            cnt   <= '0;
            state <= IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_spi_reader_chk.sv
module sar_spi_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);
  // R6
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(mosi));
  // R11
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !$past(busy));
  // R12
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
endmodule

bind sar_spi_reader sar_spi_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/sar_spi_reader_test.sv
module sar_spi_reader_test;
  localparam int CLK_DIV = 2;
  localparam int TCK = 20;

  logic clk = 0, rst_n = 0, start = 0, diff = 0;
  logic [3:0] dev = 0;
  logic [2:0] chan = 0;
  logic busy, done, sclk, cs_n, mosi, miso;
  logic [15:0] result;

  sar_spi_reader #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev(dev), .chan(chan),
    .diff(diff), .busy(busy), .done(done), .result(result),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #(TCK/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [15:0] q_res[$];
  logic [7:0]  q_cmd[$];
  int          q_bits[$];
  string       q_tag[$];
  int          pushed = 0, cs_falls = 0, popped = 0;

  // converter model
  logic [23:0] sh;
  logic [23:0] pattern;
  logic [7:0]  cmd_cap;
  int          nbits;
  logic        mosi_hi, period_bad, gap_bad, have_rise;
  time         last_sclk, cs_rise_t;
  assign miso = sh[23];

  initial begin
    sh = 0; pattern = 0; cmd_cap = 0; nbits = 0; mosi_hi = 0;
    period_bad = 0; gap_bad = 0; have_rise = 0; last_sclk = 0; cs_rise_t = 0;
  end

  always @(negedge cs_n) begin
    sh = pattern; nbits = 0; cmd_cap = 0; mosi_hi = 0; period_bad = 0;
    gap_bad = have_rise && (($time - cs_rise_t) < 2 * CLK_DIV * TCK);
    cs_falls++;
  end
  always @(posedge cs_n) begin cs_rise_t = $time; have_rise = 1; end
  always @(negedge sclk) if (!cs_n) sh = {sh[22:0], 1'b0};
  always @(posedge sclk) begin
    if (nbits > 0 && ($time - last_sclk) != 2 * CLK_DIV * TCK) period_bad = 1;
    last_sclk = $time;
    if (nbits < 8) cmd_cap = {cmd_cap[6:0], mosi};
    if (mosi) mosi_hi = 1;
    nbits++;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_multi(input logic [3:0] d);
    return d[1:0] != 0 && !d[3];
  endfunction

  function automatic logic [7:0] exp_cmd(input logic [3:0] d, input logic [2:0] c, input logic df);
    int v;
    case (d)
      1, 5:    v = (1 << 4) | (int'(!df) << 3) | (int'(c & 3'd1) << 2);
      2, 6:    v = (1 << 6) | (int'(!df) << 5) | (int'(c & 3'd3) << 2);
      3, 7:    v = (1 << 6) | (int'(!df) << 5) | (int'(c) << 2);
      default: v = 0;
    endcase
    return v[7:0];
  endfunction

  function automatic logic [15:0] exp_res(input logic [3:0] d, input logic [15:0] data);
    int b0, b1, v;
    b0 = int'(data[15:8]); b1 = int'(data[7:0]);
    case (d)
      0:       v = ((b0 << 5) | (b1 >> 3)) & 'h3ff;
      1, 2, 3: v = ((b0 << 2) | (b1 >> 6)) & 'h3ff;
      4:       v = ((b0 << 7) | (b1 >> 1)) & 'hfff;
      5, 6, 7: v = ((b0 << 4) | (b1 >> 4)) & 'hfff;
      default: begin
        v = ((b0 & 'h1f) << 8) | b1;
        if (v & 'h1000) v = v - 'h2000;
      end
    endcase
    return v[15:0];
  endfunction

  task automatic expect_item(input logic [3:0] d, input logic [2:0] c, input logic df,
                             input logic [15:0] data, input string tag);
    pattern = is_multi(d) ? {8'hA5, data} : {data, 8'h00};
    q_res.push_back(exp_res(d, data));
    q_cmd.push_back(exp_cmd(d, c, df));
    q_bits.push_back(is_multi(d) ? 24 : 16);
    q_tag.push_back(tag);
    pushed++;
  endtask

  task automatic send(input logic [3:0] d, input logic [2:0] c, input logic df,
                      input logic [15:0] data, input string tag);
    while (busy) @(negedge clk);
    expect_item(d, c, df, data, tag);
    dev = d; chan = c; diff = df; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // monitor
  logic prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!done, "R10", "done width", done, 0);
      if (done) begin
        if (q_res.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          logic [15:0] er; logic [7:0] ec; int eb; string t;
          er = q_res.pop_front(); ec = q_cmd.pop_front();
          eb = q_bits.pop_front(); t = q_tag.pop_front();
          popped++;
          check(result === er, t, "result", result, er);
          check(nbits == eb, eb == 24 ? "R6" : "R5", "sclk count", nbits, eb);
          if (eb == 24) check(cmd_cap === ec, ec[6] ? "R4" : "R3", "command", cmd_cap, ec);
          else check(!mosi_hi, "R5", "mosi idle", mosi_hi, 0);
          check(!period_bad, "R2", "sclk period", period_bad, 0);
          check(!gap_bad, "R12", "cs gap", gap_bad, 0);
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(TCK * 150000);
    check(0, "R10", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n === 1 && sclk === 0 && mosi === 0 && busy === 0 && done === 0 && result === 0,
          "R1", "reset outputs", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    // R7 10-bit
    send(0, 0, 0, 16'h1F_F8, "R7");
    send(0, 0, 0, 16'hE5_A0, "R7");
    send(1, 1, 0, 16'hAB_C0, "R7");
    send(2, 3, 1, 16'h3F_FF, "R7");
    send(3, 5, 0, 16'h80_40, "R7");
    // R8 12-bit
    send(4, 0, 0, 16'h1A_BE, "R8");
    send(5, 0, 1, 16'h12_34, "R8");
    send(6, 2, 0, 16'hFE_DC, "R8");
    send(7, 7, 1, 16'h5A_5F, "R8");
    send(7, 6, 0, 16'hC3_3C, "R8");
    // R9 signed 13-bit
    send(8, 0, 0, 16'h10_00, "R9");
    send(8, 0, 0, 16'h0F_FF, "R9");
    send(8, 0, 0, 16'hE1_23, "R9");
    send(12, 0, 0, 16'h1F_FF, "R9");
    // R11 start while busy is ignored
    send(3, 2, 1, 16'h6C_80, "R11");
    repeat (10) @(negedge clk);
    dev = 0; chan = 7; diff = 0; start = 1;
    repeat (20) @(negedge clk);
    start = 0;
    // R12 chained request: start raised in done cycle, held until cs falls
    while (!done) @(negedge clk);
    expect_item(5, 1, 0, 16'h9A_BC, "R12");
    dev = 5; chan = 1; diff = 0; start = 1;
    while (cs_n) @(negedge clk);
    start = 0;
    send(2, 1, 0, 16'h77_77, "R4");
    while (busy || q_res.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R10 result holds after done
    check(result === exp_res(2, 16'h7777), "R10", "result hold", result, exp_res(2, 16'h7777));
    // R11 frame count equals accepted requests
    check(cs_falls == pushed && popped == pushed, "R11", "frame count", cs_falls, pushed);
    finish_run();
  end
endmodule